// File: doc/BRIEF.md
# Burst column address sequencer

This block produces the column address order for one read or write burst of a double-data-rate memory controller. A start pulse gives it a starting column address, a length code selecting 2, 4 or 8 beats, and an ordering mode, either sequential or interleaved. From the next cycle it presents one column address per data beat, with a valid flag and a flag on the final beat.

Only the low offset bits inside the aligned block are sequenced. The block is the group of 2, 4 or 8 columns that the burst length defines. Every bit above that offset field is copied from the starting column for the whole burst. A new start is taken while the sequencer is idle, or on the cycle of the final beat, so that bursts can run back to back. A reserved length code starts nothing and raises a one-cycle error pulse.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_vld_o`, `beat_last_o` and `len_err_o` are all 0.
- R2: A start taken while idle with a valid length code makes `beat_vld_o` 1 on the next cycle, and `col_o` equal to the starting column on that cycle.
- R3: With `ilv_i` = 0 (sequential), the offset of beat k is (start offset + k) modulo the burst length. The order wraps inside the aligned block, so a length-8 burst from offset 5 gives 5,6,7,0,1,2,3,4.
- R4: With `ilv_i` = 1 (interleaved), the offset of beat k is the start offset XOR k. A length-8 burst from offset 5 gives 5,4,7,6,1,0,3,2, and a length-4 burst from offset 1 gives 1,0,3,2.
- R5: `len_code_i` 2'b01 selects 2 beats, 2'b10 selects 4 beats and 2'b11 selects 8 beats. The offset field is the low 1, 2 or 3 bits of the column. `beat_last_o` is 1 only on the final beat, together with `beat_vld_o`.
- R6: Column bits above the offset field keep the values of the starting column on every beat of the burst.
- R7: A start taken on the cycle where `beat_last_o` is 1 begins the next burst on the very next cycle, with no idle gap.
- R8: A start pulse during a burst, on any beat other than the last, is ignored. The running burst continues unchanged.
- R9: `len_code_i` 2'b00 is reserved. A start with this code, at a time when a start could be taken, begins no burst and makes `len_err_o` 1 for exactly the next cycle.
- R10: For a length-2 burst, both modes give the same order: 0 then 1, or 1 then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for a burst |
| col_i | input | COL_W | Starting column address |
| len_code_i | input | 2 | Burst length code: 01 = 2, 10 = 4, 11 = 8, 00 = reserved |
| ilv_i | input | 1 | Ordering mode: 0 = sequential, 1 = interleaved |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is being presented |
| beat_last_o | output | 1 | The current beat is the final one of its burst |
| len_err_o | output | 1 | One-cycle pulse after a start with a reserved length code |

## Verification
The assertions assume that `start_i`, `col_i`, `len_code_i` and `ilv_i` are stable at the rising edge and free of X while out of reset. The upper-bit hold property further assumes that one burst's column is not mixed with another's, which the start acceptance rule ensures. The scoreboard stimulus drives every input just after the falling edge and keeps it there through the next rising edge. It issues starts only when the sequencer may take them, except in the deliberate busy-start test, where a foreign start is placed on a middle beat and nothing is expected from it.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       len_code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             beat_last_o,
  output logic             len_err_o
);
  localparam int OFF_W = 3;

  logic             act_q, ilv_q, err_q;
  logic [OFF_W-1:0] cnt_q, lim_q, off;
  logic [COL_W-1:0] base_q;
  logic             take, code_ok;
  logic [OFF_W-1:0] lim_d;

  assign code_ok = len_code_i != 2'b00;
  assign lim_d   = {len_code_i == 2'b11, len_code_i[1], 1'b1};
  assign take    = start_i && (!act_q || beat_last_o);

  assign off = ilv_q ? (base_q[OFF_W-1:0] ^ cnt_q) : (base_q[OFF_W-1:0] + cnt_q);

  assign col_o       = {base_q[COL_W-1:OFF_W], (base_q[OFF_W-1:0] & ~lim_q) | (off & lim_q)};
  assign beat_vld_o  = act_q;
  assign beat_last_o = act_q && (cnt_q == lim_q);
  assign len_err_o   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ilv_q  <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
      base_q <= '0;
    end else begin
      err_q <= take && !code_ok;
      if (take && code_ok) begin
        act_q  <= 1'b1;
        ilv_q  <= ilv_i;
        cnt_q  <= '0;
        lim_q  <= lim_d;
        base_q <= col_i;
      end else if (beat_last_o) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic [1:0]       len_code_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             beat_last_o,
  input logic             len_err_o
);
  p_last_needs_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_vld_o);

  p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !beat_vld_o && len_code_i != 2'b00) |=> (beat_vld_o && col_o == $past(col_i)));

  p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && !beat_last_o) |=> (beat_vld_o && col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

  p_err_no_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_o |-> !beat_vld_o);

  p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last_o && !start_i) |=> !beat_vld_o);

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && !beat_last_o) |=> (beat_vld_o && !len_err_o));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
  .len_code_i(len_code_i), .col_o(col_o), .beat_vld_o(beat_vld_o),
  .beat_last_o(beat_last_o), .len_err_o(len_err_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
  localparam int COL_W = 10;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, ilv_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [1:0] len_code_i = 2'b00;
  logic [COL_W-1:0] col_o;
  logic beat_vld_o, beat_last_o, len_err_o;

  int total = 0, bad = 0;

  typedef struct { logic [COL_W-1:0] col; logic last; string tag; } exp_t;
  exp_t q[$];

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .col_o(col_o),
    .beat_vld_o(beat_vld_o), .beat_last_o(beat_last_o), .len_err_o(len_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && beat_vld_o) begin
      if (q.size() == 0) begin
        chk(0, "R8 unexpected beat", {22'b0, col_o}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(col_o == e.col, e.tag, {22'b0, col_o}, {22'b0, e.col});
        chk(beat_last_o == e.last, "R5 last flag", {31'b0, beat_last_o}, {31'b0, e.last});
        chk(col_o[COL_W-1:3] == e.col[COL_W-1:3], "R6 upper bits", {25'b0, col_o[COL_W-1:3]}, {25'b0, e.col[COL_W-1:3]});
      end
    end
  end

  // driver: waits until a start can be taken, pushes expected beats
  task automatic issue(input logic [COL_W-1:0] c, input logic [1:0] code, input logic il);
    int n;
    logic [2:0] m, s, o;
    bit was_last;
    string tag;
    while (beat_vld_o && !beat_last_o) @(negedge clk);
    was_last = beat_last_o;
    n = 1 << code;
    m = 3'(n - 1);
    s = c[2:0] & m;
    tag = (n == 2) ? "R10 len2 order" : (il ? "R4 interleaved order" : "R3 sequential order");
    for (int k = 0; k < n; k++) begin
      exp_t e;
      o = il ? (s ^ 3'(k)) : ((s + 3'(k)) & m);
      e.col = {c[COL_W-1:3], (c[2:0] & ~m) | (o & m)};
      e.last = (k == n - 1);
      e.tag = (k == 0) ? "R2 first beat" : tag;
      q.push_back(e);
    end
    start_i = 1'b1; col_i = c; len_code_i = code; ilv_i = il;
    @(negedge clk);
    start_i = 1'b0;
    chk(beat_vld_o == 1'b1, was_last ? "R7 back-to-back" : "R2 start from idle", {31'b0, beat_vld_o}, 1);
  endtask

  task automatic wait_idle();
    while (beat_vld_o || q.size() != 0) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "watchdog", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(beat_vld_o == 0, "R1 reset vld", {31'b0, beat_vld_o}, 0);
    chk(beat_last_o == 0, "R1 reset last", {31'b0, beat_last_o}, 0);
    chk(len_err_o == 0, "R1 reset err", {31'b0, len_err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // known orders from the requirements
    issue(10'h2A5, 2'b11, 1'b0);   // R3: 5,6,7,0,1,2,3,4
    wait_idle();
    issue(10'h2A5, 2'b11, 1'b1);   // R4: 5,4,7,6,1,0,3,2
    wait_idle();
    issue(10'h131, 2'b10, 1'b1);   // R4: 1,0,3,2
    issue(10'h131, 2'b10, 1'b0);   // R3: 1,2,3,0 back to back
    wait_idle();

    // full sweep, back to back
    for (int code = 1; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int off = 0; off < 8; off++)
          issue({7'(off * 37 + code * 11 + il * 5), 3'(off)}, 2'(code), il[0]);
    wait_idle();

    // R8: foreign start on a middle beat
    issue(10'h3F2, 2'b11, 1'b0);
    start_i = 1'b1; col_i = 10'h005; len_code_i = 2'b01; ilv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(len_err_o == 0, "R8 busy start no effect", {31'b0, len_err_o}, 0);
    wait_idle();
    @(negedge clk);
    chk(beat_vld_o == 0, "R8 no extra burst", {31'b0, beat_vld_o}, 0);

    // R9: reserved code
    start_i = 1'b1; col_i = 10'h1C3; len_code_i = 2'b00; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(len_err_o == 1, "R9 error pulse", {31'b0, len_err_o}, 1);
    chk(beat_vld_o == 0, "R9 no burst", {31'b0, beat_vld_o}, 0);
    @(negedge clk);
    chk(len_err_o == 0, "R9 pulse one cycle", {31'b0, len_err_o}, 0);
    chk(beat_vld_o == 0, "R9 still idle", {31'b0, beat_vld_o}, 0);

    // R9 on a last beat: next burst is not started
    issue(10'h0F0, 2'b01, 1'b0);
    while (!beat_last_o) @(negedge clk);
    start_i = 1'b1; len_code_i = 2'b00;
    @(negedge clk);
    start_i = 1'b0;
    chk(len_err_o == 1, "R9 error after last", {31'b0, len_err_o}, 1);
    chk(beat_vld_o == 0, "R9 idle after last", {31'b0, beat_vld_o}, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R5 all beats seen", q.size(), 0);
    finish_run();
  end
endmodule